// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block is the device side of a three-wire serial control link that owns one 8-bit control register. A host drives a serial clock, an active-low framing strobe and a serial data line. Every frame opens with a direction bit, which is 1 for a write and 0 for a read. Eight data bits follow it, least-significant bit first. A write gathers the eight bits and commits them when the strobe returns high. A read returns the register contents on a serial output, one bit per falling clock edge. The register value also drives a parallel output that the rest of the chip uses.

The block runs in a fast system-clock domain. The three serial inputs pass through a synchronizer and are edge-detected there, so the serial clock never clocks a flop. The serial clock must therefore be much slower than the system clock: each serial level has to last at least four system cycles. Resets are synchronous and active-high.

Top module: `tw_serial_regport`

## Requirements
- R1: While reset is high and in the first cycle after it, `ctrl_q` is 0x00 and both `ser_out` and `ser_out_en` are 0.
- R2: A falling edge of `frame_n` starts a frame. The first rising edge of `ser_clk` inside the frame samples the direction bit from `ser_in`: 1 selects a write and 0 selects a read.
- R3: In a write, the next eight rising edges of `ser_clk` sample the data bits LSB first. The first sampled bit goes to `ctrl_q[0]` and the last goes to `ctrl_q[7]`. `ctrl_q` takes the new value only when `frame_n` rises after all eight bits have arrived.
- R4: A frame that closes before all eight data bits are received leaves `ctrl_q` unchanged. `ctrl_q` changes at no time other than a frame close.
- R5: Rising edges of `ser_clk` after the ninth one in a frame are ignored. A write with extra edges commits the first eight data bits.
- R6: In a read, `ctrl_q` is copied to a shadow register when the direction bit is decoded. Falling edges 1 to 8 after the direction bit then place shadow bits 0 to 7 on `ser_out`. A read leaves `ctrl_q` unchanged.
- R7: `ser_out_en` is 1 from the decode of a read direction bit until the frame closes, and 0 at all other times. `ser_out` is 0 whenever `ser_out_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host, idle low |
| frame_n | input | 1 | Active-low frame strobe |
| ser_in | input | 1 | Serial data from the host |
| ser_out | output | 1 | Serial read data |
| ser_out_en | output | 1 | High while a read drives `ser_out` |
| ctrl_q | output | 8 | Parallel register value |

## Verification
The hardest cases to reach from the ports are frames whose edge count is wrong. One is a write that closes after only a few data bits. The other is a write that keeps clocking past the ninth edge. Both must leave behaviour that the outputs can show. The bench's serial tasks take a bit count, so they produce both a short frame and a frame with twelve data edges. The short frame closes on a register that already holds a known value, so an unwanted commit would show on `ctrl_q`. In the long frame, the bits after the eighth differ from the bits that should be committed.

// File: rtl/tw_serial_pkg.sv
package tw_serial_pkg;

  typedef enum logic {
    XFER_READ  = 1'b0,
    XFER_WRITE = 1'b1
  } xfer_dir_t;

  localparam int unsigned DEF_DATA_W      = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned         WIDTH   = 3,
  parameter int unsigned         STAGES  = 2,
  parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/tw_edge_det.sv
module tw_edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/tw_frame_ctrl.sv
module tw_frame_ctrl
  import tw_serial_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_fall,
  input  logic              frame_rise,
  input  logic              sclk_rise,
  input  logic              sdata,
  output logic              in_frame,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] shift_data,
  output logic              commit,
  output logic              rd_load
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W + 1);

  xfer_dir_t dir_q;
  logic      take_edge;

  assign take_edge = in_frame && sclk_rise && (bit_cnt != LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame   <= 1'b0;
      bit_cnt    <= '0;
      dir_q      <= XFER_READ;
      shift_data <= '0;
    end else if (frame_fall) begin
      in_frame <= 1'b1;
      bit_cnt  <= '0;
    end else if (frame_rise) begin
      in_frame <= 1'b0;
    end else if (take_edge) begin
      if (bit_cnt == '0) dir_q <= xfer_dir_t'(sdata);
      else               shift_data <= {sdata, shift_data[DATA_W-1:1]};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign commit  = frame_rise && in_frame && (dir_q == XFER_WRITE) && (bit_cnt == LAST_CNT);
  assign rd_load = take_edge && (bit_cnt == '0) && (sdata == 1'b0);

endmodule

// File: rtl/tw_read_shifter.sv
module tw_read_shifter
  import tw_serial_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned OCNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_load,
  input  logic              frame_end,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] reg_val,
  output logic              sout,
  output logic              sout_en
);

  localparam logic [OCNT_W-1:0] OUT_LAST = OCNT_W'(DATA_W);

  logic [DATA_W-1:0] shadow;
  logic [OCNT_W-1:0] out_cnt;

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      shadow  <= '0;
      out_cnt <= '0;
      sout    <= 1'b0;
      sout_en <= 1'b0;
    end else if (rd_load) begin
      shadow  <= reg_val;
      out_cnt <= '0;
      sout    <= 1'b0;
      sout_en <= 1'b1;
    end else if (sout_en && sclk_fall && (out_cnt != OUT_LAST)) begin
      sout    <= shadow[0];
      shadow  <= {1'b0, shadow[DATA_W-1:1]};
      out_cnt <= out_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tw_serial_regport.sv
module tw_serial_regport
  import tw_serial_pkg::*;
#(
  parameter int unsigned        DATA_W      = DEF_DATA_W,
  parameter int unsigned        SYNC_STAGES = DEF_SYNC_STAGES,
  parameter logic [DATA_W-1:0]  RESET_VAL   = '0,
  localparam int unsigned       CNT_W       = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              frame_n,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              ser_out_en,
  output logic [DATA_W-1:0] ctrl_q
);

  // bit 0: serial clock (idle low), bit 1: frame strobe (idle high), bit 2: data
  localparam logic [2:0] SYNC_RST = 3'b010;

  logic [2:0]        sync_q;
  logic [1:0]        edge_rise;
  logic [1:0]        edge_fall;
  logic              in_frame;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shift_data;
  logic              commit;
  logic              rd_load;
  logic              frame_rise;

  tw_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({ser_in, frame_n, ser_clk}),
    .q  (sync_q)
  );

  for (genvar g = 0; g < 2; g++) begin : g_edge
    tw_edge_det #(
      .RST_VAL(SYNC_RST[g])
    ) u_edge (
      .clk (clk),
      .rst (rst),
      .lvl (sync_q[g]),
      .rise(edge_rise[g]),
      .fall(edge_fall[g])
    );
  end

  assign frame_rise = edge_rise[1];

  tw_frame_ctrl #(
    .DATA_W(DATA_W)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .frame_fall(edge_fall[1]),
    .frame_rise(frame_rise),
    .sclk_rise (edge_rise[0]),
    .sdata     (sync_q[2]),
    .in_frame  (in_frame),
    .bit_cnt   (bit_cnt),
    .shift_data(shift_data),
    .commit    (commit),
    .rd_load   (rd_load)
  );

  tw_read_shifter #(
    .DATA_W(DATA_W)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_load  (rd_load),
    .frame_end(frame_rise),
    .sclk_fall(edge_fall[0]),
    .reg_val  (ctrl_q),
    .sout     (ser_out),
    .sout_en  (ser_out_en)
  );

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= RESET_VAL;
    else if (commit) ctrl_q <= shift_data;
  end

endmodule

// File: rtl/tw_serial_regport_chk.sv
module tw_serial_regport_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              ser_out,
  input logic              ser_out_en,
  input logic              frame_rise,
  input logic              commit,
  input logic              in_frame,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] shift_data
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_q == '0) && !ser_out && !ser_out_en);

  assert_commit_value_R3: assert property (@(posedge clk) disable iff (rst)
    commit |=> (ctrl_q == $past(shift_data)));

  assert_hold_outside_close_R4: assert property (@(posedge clk) disable iff (rst)
    !frame_rise |=> $stable(ctrl_q));

  assert_count_cap_R5: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(DATA_W + 1));

  assert_quiet_output_R7: assert property (@(posedge clk) disable iff (rst)
    !ser_out_en |-> !ser_out);

  assert_enable_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    ser_out_en |-> in_frame);

endmodule

bind tw_serial_regport tw_serial_regport_chk #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl_q    (ctrl_q),
  .ser_out   (ser_out),
  .ser_out_en(ser_out_en),
  .frame_rise(frame_rise),
  .commit    (commit),
  .in_frame  (in_frame),
  .bit_cnt   (bit_cnt),
  .shift_data(shift_data)
);

// File: tb/tw_serial_regport_tb.sv
module tw_serial_regport_tb;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0;
  logic       frame_n = 1'b1;
  logic       ser_in = 1'b0;
  logic       ser_out;
  logic       ser_out_en;
  logic [7:0] ctrl_q;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tw_serial_regport u_dut (
    .clk       (clk),
    .rst       (rst),
    .ser_clk   (ser_clk),
    .frame_n   (frame_n),
    .ser_in    (ser_in),
    .ser_out   (ser_out),
    .ser_out_en(ser_out_en),
    .ctrl_q    (ctrl_q)
  );

  // {op (1 = write), data, expected ctrl_q afterwards / expected read value}
  localparam logic [16:0] VEC [6] = '{
    17'h1A5A5, 17'h000A5, 17'h13C3C, 17'h10101, 17'h0FF01, 17'h18080
  };

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_clk();
    wait_sys(HALF);
    ser_clk = 1'b1;
    wait_sys(HALF);
    ser_clk = 1'b0;
    wait_sys(HALF);
  endtask

  // write frame: direction 1, then n data bits taken from bits[0..n-1]
  task automatic do_write(input logic [15:0] bits, input int n, output logic oe_seen);
    frame_n = 1'b0;
    wait_sys(HALF);
    ser_in = 1'b1;
    pulse_clk();
    oe_seen = ser_out_en;
    for (int i = 0; i < n; i++) begin
      ser_in = bits[i];
      pulse_clk();
    end
    frame_n = 1'b1;
    wait_sys(2 * HALF);
  endtask

  task automatic do_read(output logic [7:0] got, output logic oe_seen);
    frame_n = 1'b0;
    wait_sys(HALF);
    ser_in = 1'b0;
    pulse_clk();
    oe_seen = ser_out_en;
    got[0] = ser_out;
    for (int i = 1; i < 8; i++) begin
      ser_in = 1'b1;
      pulse_clk();
      got[i] = ser_out;
    end
    pulse_clk();
    frame_n = 1'b1;
    wait_sys(2 * HALF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got %h expected %h", 1'b0, 1'b1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic       oe;
    wait_sys(5);
    rst = 1'b0;
    wait_sys(1);
    chk("R1 reset ctrl_q", ctrl_q, 8'h00);
    chk("R1 reset ser_out", {7'd0, ser_out}, 8'h00);
    chk("R1 reset ser_out_en", {7'd0, ser_out_en}, 8'h00);

    for (int v = 0; v < 6; v++) begin
      if (VEC[v][16]) begin
        do_write({8'h00, VEC[v][15:8]}, 8, oe);
        chk("R3 write commit", ctrl_q, VEC[v][7:0]);
        chk("R2 write direction keeps ser_out_en low", {7'd0, oe}, 8'h00);
      end else begin
        do_read(got, oe);
        chk("R6 read serial value", got, VEC[v][7:0]);
        chk("R6 read leaves ctrl_q", ctrl_q, VEC[v][7:0]);
        chk("R2 read direction raises ser_out_en", {7'd0, oe}, 8'h01);
      end
      chk("R7 idle ser_out_en after frame", {7'd0, ser_out_en}, 8'h00);
      chk("R7 idle ser_out after frame", {7'd0, ser_out}, 8'h00);
    end

    // R4: frame closed after five data bits
    do_write(16'h005A, 5, oe);
    chk("R4 short write ignored", ctrl_q, 8'h80);

    // R4: frame closed right after the direction bit
    do_write(16'h0000, 0, oe);
    chk("R4 empty write ignored", ctrl_q, 8'h80);

    // R5: twelve data edges, only the first eight count
    do_write(16'h0F69, 12, oe);
    chk("R5 extra edges ignored", ctrl_q, 8'h69);

    do_read(got, oe);
    chk("R6 read after long write", got, 8'h69);

    // R1: reset in the middle of operation
    @(negedge clk);
    rst = 1'b1;
    wait_sys(3);
    rst = 1'b0;
    wait_sys(1);
    chk("R1 reset clears ctrl_q", ctrl_q, 8'h00);

    do_write(16'h00C3, 8, oe);
    chk("R3 write after reset", ctrl_q, 8'hC3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule